// File: doc/BRIEF.md
# Eight-Stage Pipeline Stall Controller

This block decides, every cycle, whether an eight-stage integer pipeline moves forward. The stages are IF, IS, RF, EX, DF, DS, TC and WB. Each cycle the decoder presents the instruction sitting in RF: whether it is valid, whether it is a load or a branch, whether it writes a register, and its destination and two source register numbers. The controller keeps its own record of the instructions in EX, DF, DS and TC. It uses that record to find load-use hazards and to pick a forwarding source for each RF operand. Two late events also come in. The EX stage reports whether a branch was taken, and the TC stage reports a data-cache tag hit or miss.

A load's data is ready at the end of DS. A consumer right behind a load therefore loses two cycles, and a consumer one instruction further back loses one cycle. A taken branch lets its delay-slot instruction run, and the two fetches behind the slot are squashed. When a load misses in TC, the pipeline backs up one cycle and then freezes until the refill logic raises `refill_done`. All outputs are plain control levels, with no handshake at the edge of the block. The datapath samples them in the cycle they are produced.

Top module: `pipe_stall_ctl`

## Requirements
- R1: When the youngest in-flight writer of a valid RF source register is a load in EX, `stall_front` and `bubble_ex` are high in that cycle and in the next one, so a back-to-back consumer loses exactly 2 cycles. An invalid RF slot never stalls.
- R2: When that youngest writer is a load in DF, the consumer stalls for exactly 1 cycle. From DS onward the load is forwarded with no stall.
- R3: `fwd_a`/`fwd_b` give the source for each RF operand, taken from the youngest matching writer: 0 means the register file, 1 EX, 2 DF, 3 DS and 4 TC. An invalid RF slot selects 0.
- R4: `squash_fetch` is high for one cycle when a valid branch is in EX and `ex_taken` is high. The delay-slot instruction in RF is not stalled. A not-taken branch, or `ex_taken` without a branch in EX, gives no squash.
- R5: A load in TC with `tc_hit` low raises `backup` for exactly one cycle. `hold_all` is high from that cycle through the cycle in which `refill_done` is seen, and low in the cycle after.
- R6: `tc_commit` is high when TC holds a valid register-writing instruction and the pipeline is not held. `tc_hit` has no effect unless TC holds a load.
- R7: `refill_done` has no effect while no miss is pending.
- R8: Reset empties all stage records and any pending miss. While reset is low, all outputs are low.
- R9: Register 0 is never a hazard or a forwarding target: a source of 0 selects the register file even when an in-flight instruction names 0 as its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_valid | input | 1 | RF slot holds a real instruction |
| rf_is_load | input | 1 | RF instruction is a load |
| rf_is_branch | input | 1 | RF instruction is a conditional branch |
| rf_writes | input | 1 | RF instruction writes a register |
| rf_dst | input | RW | Destination register of RF instruction |
| rf_src_a | input | RW | First source register (0 = unused) |
| rf_src_b | input | RW | Second source register (0 = unused) |
| ex_taken | input | 1 | Branch in EX resolved taken |
| tc_hit | input | 1 | Tag check result for the access in TC |
| refill_done | input | 1 | Miss service complete |
| stall_front | output | 1 | Hold IF, IS and RF |
| bubble_ex | output | 1 | Load a bubble into EX |
| squash_fetch | output | 1 | Turn IF and IS contents into bubbles |
| backup | output | 1 | Back the pipeline up one cycle for a miss |
| hold_all | output | 1 | Freeze every stage |
| fwd_a | output | 3 | Forwarding source for first operand |
| fwd_b | output | 3 | Forwarding source for second operand |
| tc_commit | output | 1 | TC result may pass to WB and write back |

## Verification
Every output is combinational from the stage records and the present inputs. Each result is therefore due in the same cycle as the stimulus that causes it. The stage records move only on a rising edge. A producer presented in RF in cycle n is seen as EX in cycle n+1, as DF in n+2, as DS in n+3 and as TC in n+4, unless a hold intervenes. The bench drives each vector just after a falling edge and samples the outputs 2 ns later, before the next rising edge. The expected values in the table were worked out by walking those stage positions cycle by cycle, including the frozen cycles of a miss.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int NSTAGE = 4;
  localparam int ST_EX  = 0;
  localparam int ST_DF  = 1;
  localparam int ST_DS  = 2;
  localparam int ST_TC  = 3;
  localparam int SEL_W  = $clog2(NSTAGE + 1);

  typedef enum logic [SEL_W-1:0] {
    SRC_REGF = 3'd0,
    SRC_EX   = 3'd1,
    SRC_DF   = 3'd2,
    SRC_DS   = 3'd3,
    SRC_TC   = 3'd4
  } fwd_src_e;

  typedef enum logic {
    MS_RUN  = 1'b0,
    MS_WAIT = 1'b1
  } miss_state_e;
endpackage

// File: rtl/stc_stage_track.sv
module stc_stage_track #(
  parameter int RW  = 5,
  parameter int NST = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    ins_bubble,
  input  logic                    in_valid,
  input  logic                    in_load,
  input  logic                    in_branch,
  input  logic                    in_writes,
  input  logic [RW-1:0]           in_dst,
  output logic [NST-1:0]          st_v,
  output logic [NST-1:0]          st_ld,
  output logic [NST-1:0]          st_wr,
  output logic [NST-1:0][RW-1:0]  st_rd,
  output logic                    ex_branch
);
  // First record (EX) takes the RF instruction or a bubble.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v[0]   <= 1'b0;
      st_ld[0]  <= 1'b0;
      st_wr[0]  <= 1'b0;
      st_rd[0]  <= '0;
      ex_branch <= 1'b0;
    end else if (adv) begin
      st_v[0]   <= in_valid & ~ins_bubble;
      st_ld[0]  <= in_valid & ~ins_bubble & in_load;
      st_wr[0]  <= in_valid & ~ins_bubble & in_writes;
      st_rd[0]  <= (in_valid & ~ins_bubble) ? in_dst : '0;
      ex_branch <= in_valid & ~ins_bubble & in_branch;
    end
  end

  // Later records shift one stage per advancing cycle.
  for (genvar g = 1; g < NST; g++) begin : g_shift
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_v[g]  <= 1'b0;
        st_ld[g] <= 1'b0;
        st_wr[g] <= 1'b0;
        st_rd[g] <= '0;
      end else if (adv) begin
        st_v[g]  <= st_v[g-1];
        st_ld[g] <= st_ld[g-1];
        st_wr[g] <= st_wr[g-1];
        st_rd[g] <= st_rd[g-1];
      end
    end
  end
endmodule

// File: rtl/stc_operand_check.sv
module stc_operand_check
  import stc_pkg::*;
#(
  parameter int RW  = 5,
  parameter int NST = 4
) (
  input  logic                    rf_valid,
  input  logic [RW-1:0]           src,
  input  logic [NST-1:0]          st_v,
  input  logic [NST-1:0]          st_ld,
  input  logic [NST-1:0]          st_wr,
  input  logic [NST-1:0][RW-1:0]  st_rd,
  output logic [SEL_W-1:0]        sel,
  output logic                    need_stall
);
  // Scan oldest to youngest so the youngest match wins.
  always_comb begin
    sel        = SRC_REGF;
    need_stall = 1'b0;
    for (int i = NST - 1; i >= 0; i--) begin
      if (rf_valid && (src != '0) && st_v[i] && st_wr[i] && (st_rd[i] == src)) begin
        sel        = SEL_W'(i + 1);
        need_stall = st_ld[i] && (i <= ST_DF);
      end
    end
  end
endmodule

// File: rtl/stc_miss_seq.sv
module stc_miss_seq
  import stc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tc_load,
  input  logic tc_hit,
  input  logic refill_done,
  output logic freeze,
  output logic backup
);
  miss_state_e state, state_nx;
  logic        miss_now;

  assign miss_now = (state == MS_RUN) && tc_load && !tc_hit;
  assign backup   = miss_now;
  assign freeze   = miss_now || (state == MS_WAIT);

  always_comb begin
    state_nx = state;
    case (state)
      MS_RUN:  if (miss_now)    state_nx = MS_WAIT;
      MS_WAIT: if (refill_done) state_nx = MS_RUN;
      default: state_nx = MS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= MS_RUN;
    else        state <= state_nx;
  end
endmodule

// File: rtl/pipe_stall_ctl.sv
module pipe_stall_ctl
  import stc_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_valid,
  input  logic              rf_is_load,
  input  logic              rf_is_branch,
  input  logic              rf_writes,
  input  logic [RW-1:0]     rf_dst,
  input  logic [RW-1:0]     rf_src_a,
  input  logic [RW-1:0]     rf_src_b,
  input  logic              ex_taken,
  input  logic              tc_hit,
  input  logic              refill_done,
  output logic              stall_front,
  output logic              bubble_ex,
  output logic              squash_fetch,
  output logic              backup,
  output logic              hold_all,
  output logic [SEL_W-1:0]  fwd_a,
  output logic [SEL_W-1:0]  fwd_b,
  output logic              tc_commit
);
  localparam int NOPS = 2;

  logic [NSTAGE-1:0]         st_v, st_ld, st_wr;
  logic [NSTAGE-1:0][RW-1:0] st_rd;
  logic                      ex_branch;
  logic                      freeze, luse;
  logic [NOPS-1:0]           op_stall;
  logic [NOPS-1:0][RW-1:0]   op_src;
  logic [NOPS-1:0][SEL_W-1:0] op_sel;

  assign op_src[0] = rf_src_a;
  assign op_src[1] = rf_src_b;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    stc_operand_check #(.RW(RW), .NST(NSTAGE)) u_op (
      .rf_valid   (rf_valid),
      .src        (op_src[k]),
      .st_v       (st_v),
      .st_ld      (st_ld),
      .st_wr      (st_wr),
      .st_rd      (st_rd),
      .sel        (op_sel[k]),
      .need_stall (op_stall[k])
    );
  end

  assign luse = |op_stall;

  stc_miss_seq u_miss (
    .clk         (clk),
    .rst_n       (rst_n),
    .tc_load     (st_v[ST_TC] & st_ld[ST_TC]),
    .tc_hit      (tc_hit),
    .refill_done (refill_done),
    .freeze      (freeze),
    .backup      (backup)
  );

  stc_stage_track #(.RW(RW), .NST(NSTAGE)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (~freeze),
    .ins_bubble (luse),
    .in_valid   (rf_valid),
    .in_load    (rf_is_load),
    .in_branch  (rf_is_branch),
    .in_writes  (rf_writes),
    .in_dst     (rf_dst),
    .st_v       (st_v),
    .st_ld      (st_ld),
    .st_wr      (st_wr),
    .st_rd      (st_rd),
    .ex_branch  (ex_branch)
  );

  assign hold_all     = freeze;
  assign stall_front  = freeze | luse;
  assign bubble_ex    = luse & ~freeze;
  assign squash_fetch = st_v[ST_EX] & ex_branch & ex_taken & ~freeze;
  assign tc_commit    = st_v[ST_TC] & st_wr[ST_TC] & ~freeze;
  assign fwd_a        = op_sel[0];
  assign fwd_b        = op_sel[1];
endmodule

// File: rtl/stall_ctl_chk.sv
module stall_ctl_chk #(
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_front,
  input logic          bubble_ex,
  input logic          squash_fetch,
  input logic          backup,
  input logic          hold_all,
  input logic [SW-1:0] fwd_a,
  input logic [SW-1:0] fwd_b,
  input logic          tc_commit,
  input logic          refill_done
);
  assert_bubble_with_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |-> stall_front);

  assert_fwd_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a <= SW'(4)) && (fwd_b <= SW'(4)));

  assert_no_squash_when_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    squash_fetch |-> !hold_all);

  assert_backup_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    backup |=> (!backup && hold_all));

  assert_hold_ends_after_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_all) |-> $past(refill_done));

  assert_no_commit_when_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_all |-> !tc_commit);
endmodule

bind pipe_stall_ctl stall_ctl_chk #(.SW(stc_pkg::SEL_W)) u_chk (.*);

// File: tb/tb_pipe_stall_ctl.sv
module tb_pipe_stall_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rf_valid, rf_is_load, rf_is_branch, rf_writes;
  logic [4:0] rf_dst, rf_src_a, rf_src_b;
  logic       ex_taken, tc_hit, refill_done;
  logic       stall_front, bubble_ex, squash_fetch, backup, hold_all, tc_commit;
  logic [2:0] fwd_a, fwd_b;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pipe_stall_ctl #(.RW(5)) dut (.*);

  // in : v ld br wr rd[5] rs1[5] rs2[5] tk hit dn
  // exp: stall bub squash backup hold fwd_a[3] fwd_b[3] commit
  localparam int N = 18;
  localparam logic [33:0] TAB [N] = '{
    {1'b1,1'b1,1'b0,1'b1,5'd5, 5'd1, 5'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,5'd6, 5'd5, 5'd2,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,3'd1,3'd0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,5'd6, 5'd5, 5'd2,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,3'd2,3'd0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,5'd6, 5'd5, 5'd2,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd3,3'd0,1'b0},
    {1'b1,1'b1,1'b0,1'b1,5'd7, 5'd6, 5'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd1,3'd0,1'b1},
    {1'b1,1'b0,1'b0,1'b1,5'd8, 5'd3, 5'd4,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,5'd9, 5'd7, 5'd6,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,3'd2,3'd3,1'b0},
    {1'b1,1'b0,1'b0,1'b1,5'd9, 5'd7, 5'd6,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd3,3'd4,1'b1},
    {1'b1,1'b0,1'b1,1'b0,5'd0, 5'd9, 5'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b1,3'd1,3'd0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,5'd0, 5'd9, 5'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1,3'd1,3'd0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,5'd0, 5'd9, 5'd0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1,3'd1,3'd0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,5'd0, 5'd9, 5'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd1,3'd0,1'b1},
    {1'b1,1'b0,1'b0,1'b1,5'd10,5'd9, 5'd0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0,3'd2,3'd0,1'b1},
    {1'b0,1'b0,1'b0,1'b0,5'd0, 5'd10,5'd0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,5'd0, 5'd0, 5'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd0,1'b1},
    {1'b1,1'b0,1'b1,1'b0,5'd0, 5'd10,5'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd3,3'd0,1'b0},
    {1'b1,1'b1,1'b0,1'b1,5'd0, 5'd0, 5'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd0,1'b1},
    {1'b1,1'b0,1'b0,1'b1,5'd11,5'd0, 5'd0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd0,1'b0}
  };

  localparam logic [21:0] IDLE = 22'h2;  // nothing in RF, tag hit

  function automatic logic [11:0] outs();
    return {stall_front, bubble_ex, squash_fetch, backup, hold_all, fwd_a, fwd_b, tc_commit};
  endfunction

  task automatic drive(input logic [21:0] iv);
    {rf_valid, rf_is_load, rf_is_branch, rf_writes, rf_dst, rf_src_a, rf_src_b,
     ex_taken, tc_hit, refill_done} = iv;
  endtask

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [21:0] iv);
    @(negedge clk);
    drive(iv);
    #2;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(22'h0);
    repeat (2) @(negedge clk);
    #2;
    check("R8 outputs low in reset", outs(), 12'h0);

    // Table walk: load-use, forwarding, miss, branch cases.
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i == 0) rst_n = 1'b1;
      drive(TAB[i][33:12]);
      #2;
      check($sformatf("table row %0d (R1 R2 R3 R4 R5 R6 R7 R9)", i), outs(), TAB[i][11:0]);
    end

    // Drain the pipeline.
    repeat (4) step(IDLE);

    // R1: invalid RF slot behind a load must not stall.
    step({1'b1,1'b1,1'b0,1'b1,5'd2,5'd0,5'd0,1'b0,1'b1,1'b0});
    step({1'b0,1'b0,1'b0,1'b0,5'd0,5'd2,5'd0,1'b0,1'b1,1'b0});
    check("R1 invalid slot no stall", {stall_front, fwd_a}, {1'b0, 3'd0});
    // R2: consumer two behind the load stalls once, then forwards from DS.
    step({1'b1,1'b0,1'b0,1'b1,5'd3,5'd2,5'd0,1'b0,1'b1,1'b0});
    check("R2 one-cycle stall, DF source", {stall_front, bubble_ex, fwd_a}, {1'b1, 1'b1, 3'd2});
    step({1'b1,1'b0,1'b0,1'b1,5'd3,5'd2,5'd0,1'b0,1'b1,1'b0});
    check("R2 released, DS source", {stall_front, bubble_ex, fwd_a}, {1'b0, 1'b0, 3'd3});
    repeat (4) step(IDLE);

    // R5 and R8: miss, then reset while waiting for refill.
    step({1'b1,1'b1,1'b0,1'b1,5'd1,5'd0,5'd0,1'b0,1'b1,1'b0});
    repeat (3) step(IDLE);
    step(22'h0);
    check("R5 miss backs up and holds", {backup, hold_all, tc_commit}, {1'b1, 1'b1, 1'b0});
    step(22'h0);
    check("R5 hold continues without refill", {backup, hold_all, stall_front}, {1'b0, 1'b1, 1'b1});
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R8 reset clears pending miss", outs(), 12'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(22'h0);
    #2;
    check("R8 empty after reset release", outs(), 12'h0);

    finish_run();
  end
endmodule